// File: doc/BRIEF.md
# Four-Channel Fixed-Priority DMA Controller

This block moves data between memory and I/O devices on a shared system bus without CPU involvement. Software gives each channel a start address, a transfer count and a control word that sets the direction, the transfer mode and an enable bit. A device asks for service by raising its request line. The controller picks the lowest-numbered unmasked requester and raises a bus request. It then waits for the bus grant before it runs transfer cycles for that channel.

Each transfer cycle lasts one clock. During that clock the controller drives the acknowledge line of the serviced device and puts the channel's current address on the memory address bus. It also asserts one memory strobe and the opposite I/O strobe, so the device and the memory exchange the data directly. Three modes decide how long the bus is held. Single mode gives the bus back after every transfer. Block mode keeps it until the count runs out. Demand mode keeps it while the device's request stays high.

The count register holds the number of transfers minus one. The transfer that finds the count at zero is the last one, and the terminal-count output is high during it. After that transfer the channel records completion and masks itself.

Top module: `blkmove_dmac`

## Requirements
- R1: After reset, hold, every acknowledge line, every strobe and tc are low, every channel is masked and every done bit is clear.
- R2: A configuration write targets the channel on cfg_chan, and cfg_sel selects the field. cfg_sel 0 loads the address and cfg_sel 1 loads the count. cfg_sel 2 loads the control word: bit 0 is the direction (1 memory-to-device, 0 device-to-memory), bits 2:1 are the mode (0 single, 1 block, 2 demand, 3 treated as single) and bit 3 is the enable. A control write unmasks the channel when bit 3 is 1, masks it when bit 3 is 0, and always clears that channel's done bit.
- R3: Among unmasked channels with dreq high, the lowest-numbered channel is serviced first. A masked channel's request never raises hold.
- R4: hold rises in the cycle after a serviceable request is seen. No acknowledge line or strobe is asserted until hlda has been sampled high.
- R5: In a transfer cycle, exactly one dack bit is high and mem_addr carries the channel's current address. Device-to-memory transfers assert io_rd with mem_wr. Memory-to-device transfers assert mem_rd with io_wr.
- R6: Each transfer increments the channel's address by one and decrements its count by one, so a count of N-1 yields exactly N transfers.
- R7: In single mode, hold is low in the cycle after every transfer.
- R8: In block mode, transfers follow back to back whatever dreq does, until terminal count.
- R9: In demand mode, transfers continue while dreq stays high. If dreq falls before terminal count, the bus is released and the address and count are kept, so a later request resumes where the transfer stopped.
- R10: tc is high during the transfer that finds the count at zero. The channel then sets its done bit, masks itself and releases hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_chan | input | 2 | Channel targeted by the write |
| cfg_sel | input | 2 | Field select: 0 address, 1 count, 2 control |
| cfg_wdata | input | 16 | Write data |
| dreq | input | 4 | Device service requests |
| hlda | input | 1 | Bus grant from the bus owner |
| hold | output | 1 | Bus request |
| dack | output | 4 | Device acknowledge, one-hot during a transfer |
| mem_addr | output | 16 | Memory address during a transfer, zero otherwise |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| io_rd | output | 1 | I/O read strobe |
| io_wr | output | 1 | I/O write strobe |
| tc | output | 1 | Terminal count, high on the final transfer |
| done | output | 4 | Per-channel completion status |

## Verification
The bench raises requests on a high and a low channel in the same cycle. A design with reversed or rotating priority would acknowledge channel 2 first and fall out of step with the reference on dack and mem_addr. In demand mode the bench drops the request partway through the count and raises it again later. A design that reloads or loses the address would restart at the wrong address, and one that ignores the drop would keep hold high. The bench also pulses a block-mode request only briefly: a design that stopped with the request would end with too few transfers. The bench counts the cycles with tc high, compares the done bits, and checks that a channel is masked once its count is used up or it has been disabled. These checks catch an off-by-one count, a missing tc or a channel that keeps requesting the bus.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

   typedef enum logic [1:0] {
      MODE_SINGLE = 2'd0,
      MODE_BLOCK  = 2'd1,
      MODE_DEMAND = 2'd2,
      MODE_RSVD   = 2'd3
   } xfer_mode_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_REQ  = 2'd1,
      ST_XFER = 2'd2
   } seq_state_e;

   localparam logic [1:0] SEL_ADDR  = 2'd0;
   localparam logic [1:0] SEL_COUNT = 2'd1;
   localparam logic [1:0] SEL_CTRL  = 2'd2;

   localparam int CTRL_DIR     = 0;
   localparam int CTRL_MODE_LO = 1;
   localparam int CTRL_MODE_HI = 2;
   localparam int CTRL_EN      = 3;
   localparam int CTRL_BITS    = 4;

endpackage

// File: rtl/dmac_chan.sv
module dmac_chan
   import dmac_pkg::*;
#(
   parameter int AW = 16,
   parameter int CW = 16,
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [1:0]    wr_sel,
   input  logic [DW-1:0] wr_data,
   input  logic          step,
   output logic [AW-1:0] addr_o,
   output logic          last_o,
   output logic          dir_o,
   output xfer_mode_e    mode_o,
   output logic          mask_o,
   output logic          done_o
);

   localparam logic [AW-1:0] ADDR_INC = AW'(1);
   localparam logic [CW-1:0] CNT_DEC  = CW'(1);

   logic [AW-1:0] addr_q;
   logic [CW-1:0] cnt_q;
   logic          dir_q;
   xfer_mode_e    mode_q;
   logic          mask_q;
   logic          done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         cnt_q  <= '0;
         dir_q  <= 1'b0;
         mode_q <= MODE_SINGLE;
         mask_q <= 1'b1;
         done_q <= 1'b0;
      end else if (wr_en) begin
         case (wr_sel)
            SEL_ADDR:  addr_q <= wr_data[AW-1:0];
            SEL_COUNT: cnt_q  <= wr_data[CW-1:0];
            SEL_CTRL: begin
               dir_q  <= wr_data[CTRL_DIR];
               mode_q <= xfer_mode_e'(wr_data[CTRL_MODE_HI:CTRL_MODE_LO]);
               mask_q <= ~wr_data[CTRL_EN];
               done_q <= 1'b0;
            end
            default: ;
         endcase
      end else if (step) begin
         addr_q <= addr_q + ADDR_INC;
         cnt_q  <= cnt_q - CNT_DEC;
         if (cnt_q == '0) begin
            done_q <= 1'b1;
            mask_q <= 1'b1;
         end
      end
   end

   assign addr_o = addr_q;
   assign last_o = (cnt_q == '0);
   assign dir_o  = dir_q;
   assign mode_o = mode_q;
   assign mask_o = mask_q;
   assign done_o = done_q;

   a_r10_self_mask: assert property (@(posedge clk) disable iff (!rst_n)
      (step && last_o && !wr_en) |=> (mask_o && done_o));

   a_r9_addr_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (!step && !wr_en) |=> $stable(addr_o));

endmodule

// File: rtl/dmac_prio_arb.sv
module dmac_prio_arb #(
   parameter int NCH = 4,
   localparam int IW = $clog2(NCH)
) (
   input  logic [NCH-1:0] req,
   output logic           any_o,
   output logic [IW-1:0]  idx_o
);

   always_comb begin
      any_o = |req;
      idx_o = '0;
      for (int i = NCH - 1; i >= 0; i--) begin
         if (req[i]) idx_o = IW'(i);
      end
   end

endmodule

// File: rtl/dmac_seq.sv
module dmac_seq
   import dmac_pkg::*;
#(
   parameter int NCH = 4,
   localparam int IW = $clog2(NCH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          pend_any,
   input  logic [IW-1:0] pend_idx,
   input  logic          hlda,
   input  logic          sel_dreq,
   input  xfer_mode_e    sel_mode,
   input  logic          sel_last,
   output logic [IW-1:0] win_o,
   output logic          hold_o,
   output logic          xfer_o
);

   seq_state_e    st_q;
   logic [IW-1:0] win_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         win_q <= '0;
      end else begin
         case (st_q)
            ST_IDLE: begin
               if (pend_any) begin
                  win_q <= pend_idx;
                  st_q  <= ST_REQ;
               end
            end
            ST_REQ: begin
               if (hlda) st_q <= ST_XFER;
            end
            ST_XFER: begin
               if (sel_last) begin
                  st_q <= ST_IDLE;
               end else begin
                  case (sel_mode)
                     MODE_BLOCK:  st_q <= ST_XFER;
                     MODE_DEMAND: st_q <= sel_dreq ? ST_XFER : ST_IDLE;
                     default:     st_q <= ST_IDLE;
                  endcase
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign win_o  = win_q;
   assign hold_o = (st_q != ST_IDLE);
   assign xfer_o = (st_q == ST_XFER);

   a_r4_grant_before_xfer: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_o && !xfer_o && !hlda) |=> !xfer_o);

   a_r7_single_release: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_o && sel_mode == MODE_SINGLE) |=> !hold_o);

   a_r8_block_continues: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_o && sel_mode == MODE_BLOCK && !sel_last) |=> xfer_o);

   a_r10_release_after_tc: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_o && sel_last) |=> !hold_o);

endmodule

// File: rtl/blkmove_dmac.sv
module blkmove_dmac
   import dmac_pkg::*;
#(
   parameter int NCH = 4,
   parameter int AW  = 16,
   parameter int CW  = 16,
   parameter int DW  = 16,
   localparam int IW = $clog2(NCH)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           cfg_wr,
   input  logic [IW-1:0]  cfg_chan,
   input  logic [1:0]     cfg_sel,
   input  logic [DW-1:0]  cfg_wdata,
   input  logic [NCH-1:0] dreq,
   input  logic           hlda,
   output logic           hold,
   output logic [NCH-1:0] dack,
   output logic [AW-1:0]  mem_addr,
   output logic           mem_rd,
   output logic           mem_wr,
   output logic           io_rd,
   output logic           io_wr,
   output logic           tc,
   output logic [NCH-1:0] done
);

   generate
      if (NCH < 2 || NCH != (1 << IW)) begin : g_bad_nch
         $error("NCH must be a power of two, at least 2");
      end
      if (AW > DW || CW > DW) begin : g_bad_width
         $error("AW and CW must fit in DW");
      end
      if (DW < CTRL_BITS) begin : g_bad_dw
         $error("DW too narrow for the control word");
      end
   endgenerate

   logic [AW-1:0] addr_a [NCH];
   logic [NCH-1:0] last_v, dir_v, mask_v, step_v, wr_v;
   xfer_mode_e    mode_a [NCH];

   logic          pend_any, xfer, sel_dir;
   logic [IW-1:0] pend_idx, win;

   dmac_seq #(.NCH(NCH)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .pend_any (pend_any),
      .pend_idx (pend_idx),
      .hlda     (hlda),
      .sel_dreq (dreq[win]),
      .sel_mode (mode_a[win]),
      .sel_last (last_v[win]),
      .win_o    (win),
      .hold_o   (hold),
      .xfer_o   (xfer)
   );

   dmac_prio_arb #(.NCH(NCH)) u_arb (
      .req   (dreq & ~mask_v),
      .any_o (pend_any),
      .idx_o (pend_idx)
   );

   for (genvar c = 0; c < NCH; c++) begin : g_chan
      assign wr_v[c]   = cfg_wr && (cfg_chan == IW'(c));
      assign step_v[c] = xfer && (win == IW'(c));
      assign dack[c]   = step_v[c];

      dmac_chan #(.AW(AW), .CW(CW), .DW(DW)) u_chan (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (wr_v[c]),
         .wr_sel  (cfg_sel),
         .wr_data (cfg_wdata),
         .step    (step_v[c]),
         .addr_o  (addr_a[c]),
         .last_o  (last_v[c]),
         .dir_o   (dir_v[c]),
         .mode_o  (mode_a[c]),
         .mask_o  (mask_v[c]),
         .done_o  (done[c])
      );
   end

   assign sel_dir  = dir_v[win];
   assign mem_addr = xfer ? addr_a[win] : '0;
   assign mem_rd   = xfer && sel_dir;
   assign io_wr    = xfer && sel_dir;
   assign io_rd    = xfer && !sel_dir;
   assign mem_wr   = xfer && !sel_dir;
   assign tc       = xfer && last_v[win];

   a_r5_dack_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(dack));

   a_r5_strobe_pairing: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr |-> (io_rd && !mem_rd && !io_wr)) and (mem_rd |-> (io_wr && !io_rd)));

   a_r4_strobes_need_bus: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd || mem_wr) |-> (hold && |dack));

   a_r10_tc_in_transfer: assert property (@(posedge clk) disable iff (!rst_n)
      tc |-> ($countones(dack) == 1));

endmodule

// File: tb/blkmove_dmac_tb.sv
module blkmove_dmac_tb;

   localparam int NCH = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [1:0]  cfg_chan = '0;
   logic [1:0]  cfg_sel = '0;
   logic [15:0] cfg_wdata = '0;
   logic [3:0]  dreq = '0;
   logic        hlda;
   logic        hold, mem_rd, mem_wr, io_rd, io_wr, tc;
   logic [3:0]  dack, done;
   logic [15:0] mem_addr;

   always #2.5 clk = ~clk;

   blkmove_dmac u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_chan(cfg_chan),
      .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .dreq(dreq), .hlda(hlda),
      .hold(hold), .dack(dack), .mem_addr(mem_addr), .mem_rd(mem_rd),
      .mem_wr(mem_wr), .io_rd(io_rd), .io_wr(io_wr), .tc(tc), .done(done)
   );

   // bus owner grants one cycle after the request
   always @(posedge clk or negedge rst_n)
      if (!rst_n) hlda <= 1'b0;
      else        hlda <= hold;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   int xf [NCH];
   int tcs    = 0;
   int first_ch = -1;

   // reference model state
   int          ms;
   int          mwin;
   logic [15:0] maddr [NCH];
   logic [15:0] mcnt  [NCH];
   logic        mdir  [NCH];
   int          mmode [NCH];
   logic        mmask [NCH];
   logic        mdone [NCH];

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   always @(posedge clk) begin
      int found;
      bit last;
      if (!rst_n) begin
         ms = 0; mwin = 0;
         for (int i = 0; i < NCH; i++) begin
            maddr[i] = '0; mcnt[i] = '0; mdir[i] = 1'b0;
            mmode[i] = 0; mmask[i] = 1'b1; mdone[i] = 1'b0;
         end
      end else begin
         if (ms == 0) begin
            found = -1;
            for (int i = 0; i < NCH; i++)
               if (found < 0 && dreq[i] && !mmask[i]) found = i;
            if (found >= 0) begin mwin = found; ms = 1; end
         end else if (ms == 1) begin
            if (hlda) ms = 2;
         end else begin
            last = (mcnt[mwin] == 16'd0);
            maddr[mwin] = maddr[mwin] + 16'd1;
            mcnt[mwin]  = mcnt[mwin] - 16'd1;
            if (last) begin
               mdone[mwin] = 1'b1; mmask[mwin] = 1'b1; ms = 0;
            end else if (mmode[mwin] == 1) ms = 2;
            else if (mmode[mwin] == 2 && dreq[mwin]) ms = 2;
            else ms = 0;
         end
         if (cfg_wr) begin
            if (cfg_sel == 2'd0) maddr[cfg_chan] = cfg_wdata;
            else if (cfg_sel == 2'd1) mcnt[cfg_chan] = cfg_wdata;
            else if (cfg_sel == 2'd2) begin
               mdir[cfg_chan]  = cfg_wdata[0];
               mmode[cfg_chan] = int'(cfg_wdata[2:1]);
               mmask[cfg_chan] = ~cfg_wdata[3];
               mdone[cfg_chan] = 1'b0;
            end
         end
      end
   end

   // per-cycle comparison away from the active edge
   always @(negedge clk) begin
      logic [3:0]  e_dack, e_done;
      logic [15:0] e_addr;
      bit e_x;
      if (rst_n) begin
         e_x    = (ms == 2);
         e_dack = e_x ? (4'b1 << mwin) : 4'b0;
         e_addr = e_x ? maddr[mwin] : 16'd0;
         for (int i = 0; i < NCH; i++) e_done[i] = mdone[i];
         chk(hold == (ms != 0), "R4", "hold", hold, ms != 0);
         chk(dack == e_dack, "R3", "dack", dack, e_dack);
         chk(mem_addr == e_addr, "R5", "mem_addr", mem_addr, e_addr);
         chk({mem_rd, io_wr, io_rd, mem_wr} ==
             {e_x && mdir[mwin], e_x && mdir[mwin], e_x && !mdir[mwin], e_x && !mdir[mwin]},
             "R5", "strobes", {mem_rd, io_wr, io_rd, mem_wr}, 0);
         chk(tc == (e_x && mcnt[mwin] == 16'd0), "R10", "tc", tc, e_x && mcnt[mwin] == 16'd0);
         chk(done == e_done, "R10", "done", done, e_done);
         for (int i = 0; i < NCH; i++)
            if (dack[i]) begin
               xf[i]++;
               if (first_ch < 0) first_ch = i;
            end
         if (tc) tcs++;
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         fails++; checks++;
         $display("FAIL watchdog: actual %0d expected below 20000 cycles", cyc);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   task automatic wr(input int ch, input int sel, input int data);
      cfg_wr = 1'b1; cfg_chan = 2'(ch); cfg_sel = 2'(sel); cfg_wdata = 16'(data);
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic prog(input int ch, input int a, input int n, input int mode, input int dir);
      wr(ch, 0, a);
      wr(ch, 1, n - 1);
      wr(ch, 2, 8 | (mode << 1) | dir);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin
      for (int i = 0; i < NCH; i++) xf[i] = 0;
      idle(3);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk(hold == 0 && dack == 0 && tc == 0, "R1", "hold/dack/tc", {hold, dack, tc}, 0);
      chk({mem_rd, mem_wr, io_rd, io_wr} == 0 && done == 0, "R1", "strobes/done",
          {mem_rd, mem_wr, io_rd, io_wr, done}, 0);
      dreq = 4'b1111;
      idle(6);
      chk(hold == 0, "R1", "masked after reset", hold, 0);
      dreq = 4'b0000;

      // R3 priority, R6 counts, R7 single, R8 block
      prog(2, 'h100, 3, 0, 0);
      prog(0, 'h200, 4, 1, 1);
      dreq = 4'b0101;
      while (!(mdone[0] && mdone[2])) @(negedge clk);
      dreq = 4'b0000;
      idle(3);
      chk(first_ch == 0, "R3", "first channel served", first_ch, 0);
      chk(xf[0] == 4, "R6", "block transfers ch0", xf[0], 4);
      chk(xf[2] == 3, "R6", "single transfers ch2", xf[2], 3);
      chk(tcs == 2, "R10", "tc pulses", tcs, 2);
      chk(done == 4'b0101, "R10", "done bits", done, 4'b0101);

      // R2: disabling control write clears done and keeps the channel masked
      wr(0, 2, 0);
      chk(done[0] == 1'b0, "R2", "done cleared", done[0], 0);
      dreq = 4'b0001;
      idle(6);
      chk(hold == 0, "R2", "disabled channel ignored", hold, 0);
      dreq = 4'b0000;

      // R8: block runs to the end after a brief request
      prog(1, 'hFFFE, 5, 1, 0);
      dreq = 4'b0010;
      while (dack[1] == 1'b0) @(negedge clk);
      dreq = 4'b0000;
      while (!mdone[1]) @(negedge clk);
      idle(2);
      chk(xf[1] == 5, "R8", "block transfers after request drop", xf[1], 5);

      // R9: demand pauses and resumes
      prog(3, 'h0300, 6, 2, 1);
      dreq = 4'b1000;
      while (xf[3] < 2) @(negedge clk);
      dreq = 4'b0000;
      idle(2);
      chk(hold == 0, "R9", "bus released on drop", hold, 0);
      chk(done[3] == 0, "R9", "not done after pause", done[3], 0);
      idle(4);
      dreq = 4'b1000;
      while (!mdone[3]) @(negedge clk);
      dreq = 4'b0000;
      idle(3);
      chk(xf[3] == 6, "R9", "demand total transfers", xf[3], 6);
      chk(done[3] == 1, "R10", "demand done", done[3], 1);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule